// File: doc/BRIEF.md
# Multi-line synchronous serial audio port

This block is a bidirectional serial audio port that always runs as clock master. It divides the system clock down to a bit clock and derives a frame clock from it. It then moves 32-bit channel slots over up to four parallel data lines, all timed by that one bit clock. Each line carries two slots per sample period in the short frame mode, which is 64 bit clocks long. In the long frame mode, which is 128 bit clocks long, each line carries four slots.

On the host side, a flat vector holds every transmit channel, and a matching vector presents every received channel. The port takes a new transmit set, and hands over the received set with a one-cycle strobe, at the instant each frame begins. The frame length, the frame-clock polarity, the number of active lines, the 16-bit low-half blanking and the divider setting are all sampled only at a frame start. A setting changed in mid-frame therefore never truncates or stretches the frame in progress.

Top module: `sap_port`

## Requirements
- R1: The bit clock is a square wave with high and low phases of `cfg_half_i` system clocks each (a value of 0 acts as 1). After reset, `bclk_o`, `fclk_o`, `sd_o`, `rx_valid_o` and `rx_samples_o` are all zero.
- R2: A frame lasts 64 bit clocks when `cfg_wide_i`=0 and 128 bit clocks when it is 1. The frame clock has a 50% duty cycle and changes only where the bit clock falls. With `cfg_fall_i`=0 the frame clock is high for the first half of the frame, and with `cfg_fall_i`=1 it is low for the first half.
- R3: Transmit data changes only where the bit clock falls. Each slot is sent most significant bit first. The sign bit of the first slot appears at the same falling bit-clock edge at which the frame clock takes its frame-start level.
- R4: Let S be 2 (short frame) or 4 (long frame). Line n, slot s carries channel n*S+s. Channel c occupies bits [32c+31:32c] of `tx_samples_i` and `rx_samples_o`.
- R5: With `cfg_quad_i`=0, only line 0 is used. Lines 1 to 3 drive 0, their input lines are ignored, and the received channels that belong to them read 0. With `cfg_quad_i`=1, all four lines are active.
- R6: With `cfg_res16_i`=1, the transmitter drives bit periods 15 to 0 of every slot low, while bits 31 to 16 carry the sample.
- R7: Received bits are sampled where the bit clock rises. A full received set appears on `rx_samples_o`, with `rx_valid_o` high for exactly one cycle. That cycle is the one in which the frame clock takes its frame-start level.
- R8: The transmit set sent in a frame is the value of `tx_samples_i` at the system clock edge on which that frame begins.
- R9: Configuration changes take effect only at the next frame start. The frame in progress finishes with its old length, polarity, line count, blanking and divider.
- R10: No `rx_valid_o` strobe is given at the first frame start after reset, because no complete frame has yet been received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_half_i | input | DIV_W | Bit-clock half period in system clocks |
| cfg_wide_i | input | 1 | 1 selects the 128-bit frame, 0 selects the 64-bit frame |
| cfg_fall_i | input | 1 | 1 starts the frame on a falling frame-clock edge |
| cfg_quad_i | input | 1 | 1 enables four data lines, 0 enables one |
| cfg_res16_i | input | 1 | 1 drives the low 16 bit periods of each slot low |
| tx_samples_i | input | LINES*SLOTS_HI*SLOT_W | Transmit channels, channel c at bits 32c upward |
| rx_samples_o | output | LINES*SLOTS_HI*SLOT_W | Received channels of the last full frame |
| rx_valid_o | output | 1 | One-cycle strobe marking a new received set |
| bclk_o | output | 1 | Bit clock |
| fclk_o | output | 1 | Frame clock |
| sd_o | output | LINES | Serial transmit data, one bit per line |
| sd_i | input | LINES | Serial receive data, one bit per line |

## Verification
The bench builds the port with its default parameters: four lines, 32-bit slots, two or four slots per line and an 8-bit divider. All sixteen channel positions, both frame lengths and the single-line and four-line variants are therefore reachable. Divider settings of 0 to 3 keep frames short enough to run many of them, while still showing the zero-as-one rule and unequal settings from frame to frame. The bench changes the configuration in mid-frame, so each frame must keep the settings latched at its own start.

// File: rtl/sap_pkg.sv
package sap_pkg;

    // Settings sampled once per frame start
    typedef struct packed {
        logic wide;   // 1: four slots per line, 0: two slots per line
        logic fall;   // 1: frame begins on falling frame-clock edge
        logic quad;   // 1: all lines active, 0: line 0 only
        logic res16;  // 1: low half of each slot transmitted as zero
    } sap_cfg_t;

endpackage

// File: rtl/sap_bclk_gen.sv
module sap_bclk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] half_i,
    output logic             bclk_o,
    output logic             rise_o,
    output logic             fall_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             bclk;
    } gen_st_t;

    gen_st_t          st_d, st_q;
    logic             tick;
    logic [DIV_W-1:0] limit;

    always_comb begin
        limit = (half_i == '0) ? DIV_W'(1) : half_i;
        tick  = (st_q.cnt >= limit - DIV_W'(1));
        st_d  = st_q;
        if (tick) begin
            st_d.cnt  = '0;
            st_d.bclk = ~st_q.bclk;
        end else begin
            st_d.cnt = st_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bclk_o = st_q.bclk;
    assign rise_o = tick & ~st_q.bclk;
    assign fall_o = tick &  st_q.bclk;

endmodule

// File: rtl/sap_slot_map.sv
module sap_slot_map #(
    parameter int SLOT_W   = 32,
    parameter int SLOTS_LO = 2,
    parameter int SLOTS_HI = 4,
    parameter int CH_W     = 4,
    parameter int POS_W    = 7,
    parameter int LINE     = 0,
    localparam int SB_W    = $clog2(SLOT_W)
) (
    input  logic             wide_i,
    input  logic             quad_i,
    input  logic [POS_W-1:0] pos_i,
    output logic [CH_W-1:0]  ch_o,
    output logic [SB_W-1:0]  bit_o,
    output logic             en_o
);

    int slot_idx;
    int per_line;

    always_comb begin
        slot_idx = int'(pos_i >> SB_W);
        per_line = wide_i ? SLOTS_HI : SLOTS_LO;
        ch_o     = CH_W'(LINE * per_line + slot_idx);
        bit_o    = SB_W'(SLOT_W - 1) - pos_i[SB_W-1:0];
        en_o     = (LINE == 0) || quad_i;
    end

endmodule

// File: rtl/sap_port.sv
module sap_port
    import sap_pkg::*;
#(
    parameter int LINES    = 4,
    parameter int SLOT_W   = 32,
    parameter int SLOTS_LO = 2,
    parameter int SLOTS_HI = 4,
    parameter int DIV_W    = 8,
    localparam int VEC_W   = LINES * SLOTS_HI * SLOT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_half_i,
    input  logic             cfg_wide_i,
    input  logic             cfg_fall_i,
    input  logic             cfg_quad_i,
    input  logic             cfg_res16_i,
    input  logic [VEC_W-1:0] tx_samples_i,
    output logic [VEC_W-1:0] rx_samples_o,
    output logic             rx_valid_o,
    output logic             bclk_o,
    output logic             fclk_o,
    output logic [LINES-1:0] sd_o,
    input  logic [LINES-1:0] sd_i
);

    localparam int CHANS    = LINES * SLOTS_HI;
    localparam int FRAME_LO = SLOTS_LO * SLOT_W;
    localparam int FRAME_HI = SLOTS_HI * SLOT_W;
    localparam int POS_W    = $clog2(FRAME_HI);
    localparam int CH_W     = (CHANS > 1) ? $clog2(CHANS) : 1;
    localparam int SB_W     = $clog2(SLOT_W);

    typedef struct packed {
        sap_cfg_t         cfg;
        logic [DIV_W-1:0] half;
        logic [POS_W-1:0] pos;
        logic             fclk;
        logic [LINES-1:0] sd;
        logic [VEC_W-1:0] txbuf;
        logic [VEC_W-1:0] rxsh;
        logic [VEC_W-1:0] rxout;
        logic             valid;
        logic             primed;
    } port_st_t;

    port_st_t s_d, s_q;

    logic b_rise, b_fall;

    sap_bclk_gen #(.DIV_W(DIV_W)) u_bclk (
        .clk    (clk),
        .rst_n  (rst_n),
        .half_i (s_q.half),
        .bclk_o (bclk_o),
        .rise_o (b_rise),
        .fall_o (b_fall)
    );

    // Frame boundary and the settings for the next bit period
    sap_cfg_t         cfg_live, cfg_nx;
    logic             frame_end;
    logic [POS_W-1:0] pos_nx, last_pos;

    always_comb begin
        cfg_live  = '{wide: cfg_wide_i, fall: cfg_fall_i, quad: cfg_quad_i, res16: cfg_res16_i};
        last_pos  = s_q.cfg.wide ? POS_W'(FRAME_HI - 1) : POS_W'(FRAME_LO - 1);
        frame_end = b_fall && (s_q.pos == last_pos);
        cfg_nx    = frame_end ? cfg_live : s_q.cfg;
        pos_nx    = frame_end ? '0 : s_q.pos + POS_W'(1);
    end

    // Slot mapping per line: one copy for the outgoing bit, one for capture
    logic [CH_W-1:0] tx_ch  [LINES];
    logic [SB_W-1:0] tx_bit [LINES];
    logic            tx_en  [LINES];
    logic [CH_W-1:0] rx_ch  [LINES];
    logic [SB_W-1:0] rx_bit [LINES];
    logic            rx_en  [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        sap_slot_map #(
            .SLOT_W(SLOT_W), .SLOTS_LO(SLOTS_LO), .SLOTS_HI(SLOTS_HI),
            .CH_W(CH_W), .POS_W(POS_W), .LINE(g)
        ) u_map_tx (
            .wide_i (cfg_nx.wide),
            .quad_i (cfg_nx.quad),
            .pos_i  (pos_nx),
            .ch_o   (tx_ch[g]),
            .bit_o  (tx_bit[g]),
            .en_o   (tx_en[g])
        );
        sap_slot_map #(
            .SLOT_W(SLOT_W), .SLOTS_LO(SLOTS_LO), .SLOTS_HI(SLOTS_HI),
            .CH_W(CH_W), .POS_W(POS_W), .LINE(g)
        ) u_map_rx (
            .wide_i (s_q.cfg.wide),
            .quad_i (s_q.cfg.quad),
            .pos_i  (s_q.pos),
            .ch_o   (rx_ch[g]),
            .bit_o  (rx_bit[g]),
            .en_o   (rx_en[g])
        );
    end

    logic [VEC_W-1:0] tx_src;
    int               half_frame;

    always_comb begin
        s_d        = s_q;
        s_d.valid  = 1'b0;
        tx_src     = frame_end ? tx_samples_i : s_q.txbuf;
        half_frame = cfg_nx.wide ? FRAME_HI / 2 : FRAME_LO / 2;

        if (b_rise) begin
            for (int n = 0; n < LINES; n++) begin
                if (rx_en[n]) begin
                    s_d.rxsh[int'(rx_ch[n]) * SLOT_W + int'(rx_bit[n])] = sd_i[n];
                end
            end
        end

        if (b_fall) begin
            s_d.pos  = pos_nx;
            s_d.cfg  = cfg_nx;
            s_d.fclk = (int'(pos_nx) < half_frame) ^ cfg_nx.fall;
            for (int n = 0; n < LINES; n++) begin
                s_d.sd[n] = tx_en[n]
                          & tx_src[int'(tx_ch[n]) * SLOT_W + int'(tx_bit[n])]
                          & ~(cfg_nx.res16 && (tx_bit[n] < SB_W'(SLOT_W / 2)));
            end
        end

        if (frame_end) begin
            s_d.txbuf  = tx_samples_i;
            s_d.half   = cfg_half_i;
            s_d.rxout  = s_q.rxsh;
            s_d.rxsh   = '0;
            s_d.valid  = s_q.primed;
            s_d.primed = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.half <= DIV_W'(1);
            s_q.pos  <= POS_W'(FRAME_LO - 1);
        end else begin
            s_q <= s_d;
        end
    end

    logic act_quad;

    assign act_quad     = s_q.cfg.quad;
    assign rx_samples_o = s_q.rxout;
    assign rx_valid_o   = s_q.valid;
    assign fclk_o       = s_q.fclk;
    assign sd_o         = s_q.sd;

endmodule

// File: rtl/sap_port_chk.sv
module sap_port_chk #(
    parameter int LINES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bclk_o,
    input logic             fclk_o,
    input logic [LINES-1:0] sd_o,
    input logic             rx_valid_o,
    input logic             act_quad
);

    AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(bclk_o) |-> $stable(sd_o));                              // R3

    AST_FCLK_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fclk_o) |-> $fell(bclk_o));                            // R2

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);                                    // R7

    AST_VALID_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> $fell(bclk_o));                                  // R7

    AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        !act_quad |-> ((sd_o >> 1) == '0));                            // R5

endmodule

bind sap_port sap_port_chk #(.LINES(LINES)) i_sap_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bclk_o     (bclk_o),
    .fclk_o     (fclk_o),
    .sd_o       (sd_o),
    .rx_valid_o (rx_valid_o),
    .act_quad   (act_quad)
);

// File: tb/test_sap_port.sv
module test_sap_port;

    localparam int LINES = 4, SLOT_W = 32, SLOTS_LO = 2, SLOTS_HI = 4, DIV_W = 8;
    localparam int CHANS = LINES * SLOTS_HI;
    localparam int VEC_W = CHANS * SLOT_W;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [DIV_W-1:0] cfg_half_i;
    logic             cfg_wide_i, cfg_fall_i, cfg_quad_i, cfg_res16_i;
    logic [VEC_W-1:0] tx_samples_i, rx_samples_o;
    logic             rx_valid_o, bclk_o, fclk_o;
    logic [LINES-1:0] sd_o, sd_i;

    sap_port #(.LINES(LINES), .SLOT_W(SLOT_W), .SLOTS_LO(SLOTS_LO),
               .SLOTS_HI(SLOTS_HI), .DIV_W(DIV_W)) i_sap_port (
        .clk(clk), .rst_n(rst_n), .cfg_half_i(cfg_half_i), .cfg_wide_i(cfg_wide_i),
        .cfg_fall_i(cfg_fall_i), .cfg_quad_i(cfg_quad_i), .cfg_res16_i(cfg_res16_i),
        .tx_samples_i(tx_samples_i), .rx_samples_o(rx_samples_o), .rx_valid_o(rx_valid_o),
        .bclk_o(bclk_o), .fclk_o(fclk_o), .sd_o(sd_o), .sd_i(sd_i));

    always #5 clk = ~clk;

    int total = 0, bad = 0;
    logic pb = 1'b0, pf = 1'b0, pv = 1'b0;
    int   pos = 100000, falls = 0, actv = 0, lowcnt = 0, highcnt = 0, skip = 0, starts = 0;
    bit   seen_first = 1'b0;
    bit   f_wide = 1'b0, f_quad = 1'b0, f_res16 = 1'b0, f_fall = 1'b0;
    int   f_half = 1;
    logic [VEC_W-1:0]  tx_exp;
    logic [SLOT_W-1:0] rxw [CHANS];
    logic [SLOT_W-1:0] cap [LINES][SLOTS_HI];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int slots(input bit w);
        return w ? SLOTS_HI : SLOTS_LO;
    endfunction

    function automatic int eff_half(input int h);
        return (h == 0) ? 1 : h;
    endfunction

    function automatic logic [31:0] tx_word_exp(input int n, input int s);
        logic [31:0] w;
        if (!(n == 0 || f_quad)) return '0;
        w = tx_exp[(n * slots(f_wide) + s) * SLOT_W +: SLOT_W];
        if (f_res16) w[15:0] = '0;
        return w;
    endfunction

    function automatic logic [31:0] rx_word_exp(input int ch);
        if (ch < (f_quad ? LINES : 1) * slots(f_wide)) return rxw[ch];
        return '0;
    endfunction

    task automatic load_tx();
        int pat = $urandom_range(0, 3);
        for (int c = 0; c < CHANS; c++) begin
            case (pat)
                0: tx_samples_i[c*SLOT_W +: SLOT_W] = $urandom;
                1: tx_samples_i[c*SLOT_W +: SLOT_W] = 32'hFFFF_FFFF;
                2: tx_samples_i[c*SLOT_W +: SLOT_W] = 32'h8000_0000;
                default: tx_samples_i[c*SLOT_W +: SLOT_W] = 32'h0000_FFFF;
            endcase
        end
    endtask

    task automatic frame_checks();
        if (skip > 0) begin
            skip--;
            return;
        end
        chk(falls == slots(f_wide) * SLOT_W, "R2 R9 frame length", falls, slots(f_wide) * SLOT_W);
        chk(actv == slots(f_wide) * SLOT_W / 2, "R2 duty", actv, slots(f_wide) * SLOT_W / 2);
        chk(rx_valid_o == 1'b1, "R7 strobe at frame start", rx_valid_o, 1);
        for (int n = 0; n < LINES; n++)
            for (int s = 0; s < slots(f_wide); s++)
                chk(cap[n][s] == tx_word_exp(n, s),
                    $sformatf("%s tx line %0d slot %0d",
                              !(n == 0 || f_quad) ? "R5" : (f_res16 ? "R6" : "R3 R4 R8"), n, s),
                    cap[n][s], tx_word_exp(n, s));
        for (int c = 0; c < CHANS; c++)
            chk(rx_samples_o[c*SLOT_W +: SLOT_W] == rx_word_exp(c),
                $sformatf("%s rx channel %0d",
                          c < (f_quad ? LINES : 1) * slots(f_wide) ? "R4 R7" : "R5", c),
                rx_samples_o[c*SLOT_W +: SLOT_W], rx_word_exp(c));
    endtask

    task automatic step();
        bit fell, rose, start;
        @(negedge clk);
        fell = pb && !bclk_o;
        rose = !pb && bclk_o;
        if (rx_valid_o) chk(!pv, "R7 strobe width", pv, 0);
        if (fell) begin
            if (seen_first && skip == 0)
                chk(highcnt == eff_half(f_half), "R1 high phase", highcnt, eff_half(f_half));
            start = (fclk_o != pf) && (fclk_o == !cfg_fall_i);
            if (start) begin
                starts++;
                if (!seen_first) begin
                    chk(rx_valid_o == 1'b0, "R10 no strobe at first frame", rx_valid_o, 0);
                    seen_first = 1'b1;
                end else begin
                    frame_checks();
                end
                f_wide = cfg_wide_i; f_quad = cfg_quad_i; f_res16 = cfg_res16_i;
                f_fall = cfg_fall_i; f_half = int'(cfg_half_i);
                tx_exp = tx_samples_i;
                load_tx();
                for (int c = 0; c < CHANS; c++) rxw[c] = $urandom;
                for (int n = 0; n < LINES; n++)
                    for (int s = 0; s < SLOTS_HI; s++) cap[n][s] = 'x;
                pos = 0; falls = 1; actv = 0;
            end else begin
                pos++; falls++;
                if (seen_first && skip == 0)
                    chk(rx_valid_o == 1'b0, "R7 no strobe inside frame", rx_valid_o, 0);
            end
            if (fclk_o == !f_fall) actv++;
            for (int n = 0; n < LINES; n++) begin
                if (pos >= slots(f_wide) * SLOT_W) sd_i[n] = 1'b0;
                else if (n == 0 || f_quad)
                    sd_i[n] = rxw[n * slots(f_wide) + pos / SLOT_W][SLOT_W - 1 - pos % SLOT_W];
                else sd_i[n] = 1'($urandom);
            end
            lowcnt = 1;
        end else if (rose) begin
            if (seen_first && skip == 0)
                chk(lowcnt == eff_half(f_half), "R1 low phase", lowcnt, eff_half(f_half));
            if (pos < slots(f_wide) * SLOT_W)
                for (int n = 0; n < LINES; n++)
                    cap[n][pos / SLOT_W][SLOT_W - 1 - pos % SLOT_W] = sd_o[n];
            highcnt = 1;
        end else if (bclk_o) highcnt++;
        else lowcnt++;
        pb = bclk_o; pf = fclk_o; pv = rx_valid_o;
    endtask

    task automatic run_frames(input int k);
        int target = starts + k;
        while (starts < target) step();
    endtask

    task automatic run_steps(input int k);
        for (int i = 0; i < k; i++) step();
    endtask

    task automatic set_cfg(input int half, input bit wide, input bit fall, input bit quad, input bit res16);
        if (fall != cfg_fall_i) skip = 3;
        cfg_half_i = DIV_W'(half); cfg_wide_i = wide; cfg_fall_i = fall;
        cfg_quad_i = quad; cfg_res16_i = res16;
    endtask

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0; sd_i = '0;
        cfg_half_i = 1; cfg_wide_i = 0; cfg_fall_i = 0; cfg_quad_i = 1; cfg_res16_i = 0;
        load_tx();
        repeat (5) @(negedge clk);
        chk(bclk_o == 0 && fclk_o == 0 && rx_valid_o == 0, "R1 reset clocks and strobe",
            {bclk_o, fclk_o, rx_valid_o}, 0);
        chk(sd_o == '0, "R1 reset data lines", sd_o, 0);
        chk(rx_samples_o == '0, "R1 reset receive set", rx_samples_o[31:0], 0);
        rst_n = 1'b1;
        run_frames(4);                              // short frame, four lines
        run_steps(40); set_cfg(1, 1, 0, 1, 0);      // mid-frame switch to long frame (R9)
        run_frames(4);
        run_steps(70); set_cfg(2, 1, 0, 0, 0);      // single line, long frame
        run_frames(3);
        run_steps(15); set_cfg(2, 0, 0, 0, 0);      // single line, short frame
        run_frames(3);
        run_steps(30); set_cfg(1, 0, 0, 1, 1);      // 16-bit blanking
        run_frames(3);
        set_cfg(1, 0, 1, 1, 0);                     // falling-edge frame start
        run_frames(5);
        run_steps(20); set_cfg(3, 1, 1, 1, 0);
        run_frames(3);
        set_cfg(0, 0, 1, 1, 1);                     // divider 0 acts as 1
        run_frames(3);
        for (int it = 0; it < 12; it++) begin
            run_steps($urandom_range(10, 200));
            set_cfg($urandom_range(0, 3), 1'($urandom), 1'($urandom),
                    1'($urandom), 1'($urandom));
            run_frames(2);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", starts, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule